// File: doc/BRIEF.md
# Segmented DAC code decoder

This block turns a binary sample into the switch controls of a segmented current-steering converter. Each sample is split into three fields. The top field selects how many of the large equal current cells are switched on. The middle field does the same for a row of smaller equal cells. The bottom field drives binary-weighted cells directly. Because both upper fields use thermometer coding, a larger input can only add equal cells within a segment. This keeps the output monotonic.

The sample is first captured in an input register. It is then decoded, and the complete control word is captured in a second register, so that every switch changes on the same clock edge. A second output bus carries the complement of every control. It comes from its own register, for driving differential switch pairs. Both registers clear to code zero on a synchronous reset.

Top module: `segdac_decoder`

## Requirements
- R1: A code presented on `code_in` before rising edge k shows on `sw_ctrl` just after rising edge k+1. The latency is two cycles.
- R2: The coarse segment sits in `sw_ctrl[50:20]`. Its value k is `code_in[13:9]`. Exactly bits 20 through 20+k-1 are set, so value zero sets none of them. Each coarse bit weighs 512 LSB.
- R3: The fine segment sits in `sw_ctrl[19:5]`. Its value m is `code_in[8:5]`. Exactly bits 5 through 5+m-1 are set, and each fine bit weighs 32 LSB.
- R4: `sw_ctrl[4:0]` equals `code_in[4:0]` of the same sample. Bit i weighs 2^i LSB.
- R5: 512 × (ones in the coarse segment) + 32 × (ones in the fine segment) + the value of `sw_ctrl[4:0]` equals the input code.
- R6: `sw_ctrl_n` is the bitwise inverse of `sw_ctrl` in every cycle, including during reset.
- R7: After an edge with `rst` high, `sw_ctrl` is all zeros and `sw_ctrl_n` is all ones. The input register is also cleared, so the first output after reset is released still decodes code zero.
- R8: When the input steps up by one code, the weighted sum of R5 rises by exactly one. The output is monotonic over the whole range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 14 | Binary sample code |
| sw_ctrl | output | 51 | Switch controls: coarse thermometer, fine thermometer, binary LSBs |
| sw_ctrl_n | output | 51 | Bitwise complement of `sw_ctrl` for differential switches |

## Verification
The bench builds the block with its default split: 14 input bits, a 5-bit coarse field and a 4-bit fine field. Every one of the 16384 codes can then be swept in ascending order within a short run. Each code is checked field by field and through the weighted sum, and the one-code step of R8 is checked between neighbouring codes. A scattered sequence of codes exercises the two-cycle latency under large jumps. A reset in the middle of the stream checks that both registers clear.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    // Default split of the sample word
    localparam int DEF_DATA_W = 14;
    localparam int DEF_HI_W   = 5;
    localparam int DEF_MID_W  = 4;

    // Number of thermometer lines a field of the given width needs
    function automatic int therm_lines(input int field_w);
        return (1 << field_w) - 1;
    endfunction
endpackage

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
    parameter int IN_W = 4
) (
    input  logic [IN_W-1:0]          val,
    output logic [(1<<IN_W)-2:0]     therm
);
    localparam int LINES = (1 << IN_W) - 1;

    // Line j is on when the field value exceeds j
    for (genvar j = 0; j < LINES; j++) begin : g_line
        assign therm[j] = ({1'b0, val} > (IN_W+1)'(j));
    end
endmodule

// File: rtl/seg_pipe_reg.sv
module seg_pipe_reg #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
    import segdac_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int HI_W   = DEF_HI_W,
    parameter int MID_W  = DEF_MID_W
) (
    input  logic                                                         clk,
    input  logic                                                         rst,
    input  logic [DATA_W-1:0]                                            code_in,
    output logic [((1<<HI_W)-1)+((1<<MID_W)-1)+(DATA_W-HI_W-MID_W)-1:0]  sw_ctrl,
    output logic [((1<<HI_W)-1)+((1<<MID_W)-1)+(DATA_W-HI_W-MID_W)-1:0]  sw_ctrl_n
);
    localparam int LO_W   = DATA_W - HI_W - MID_W;
    localparam int HI_N   = therm_lines(HI_W);
    localparam int MID_N  = therm_lines(MID_W);
    localparam int CTRL_W = HI_N + MID_N + LO_W;

    logic [DATA_W-1:0] samp_q;
    logic [HI_N-1:0]   hi_therm;
    logic [MID_N-1:0]  mid_therm;
    logic [CTRL_W-1:0] ctrl_d;

    // Stage 1: capture the sample
    seg_pipe_reg #(.W(DATA_W), .RST_VAL('0)) u_samp (
        .clk (clk),
        .rst (rst),
        .d   (code_in),
        .q   (samp_q)
    );

    // Decode the coarse and fine fields
    seg_therm_dec #(.IN_W(HI_W)) u_hi_dec (
        .val   (samp_q[DATA_W-1 -: HI_W]),
        .therm (hi_therm)
    );

    seg_therm_dec #(.IN_W(MID_W)) u_mid_dec (
        .val   (samp_q[LO_W +: MID_W]),
        .therm (mid_therm)
    );

    always_comb begin
        ctrl_d = {hi_therm, mid_therm, samp_q[LO_W-1:0]};
    end

    // Stage 2: true and complement controls, each in its own register
    seg_pipe_reg #(.W(CTRL_W), .RST_VAL('0)) u_ctrl_p (
        .clk (clk),
        .rst (rst),
        .d   (ctrl_d),
        .q   (sw_ctrl)
    );

    seg_pipe_reg #(.W(CTRL_W), .RST_VAL('1)) u_ctrl_n (
        .clk (clk),
        .rst (rst),
        .d   (~ctrl_d),
        .q   (sw_ctrl_n)
    );
endmodule

// File: rtl/segdac_decoder_chk.sv
module segdac_decoder_chk #(
    parameter int DATA_W = 14,
    parameter int HI_W   = 5,
    parameter int MID_W  = 4
) (
    input logic                                                         clk,
    input logic                                                         rst,
    input logic [DATA_W-1:0]                                            code_in,
    input logic [((1<<HI_W)-1)+((1<<MID_W)-1)+(DATA_W-HI_W-MID_W)-1:0]  sw_ctrl,
    input logic [((1<<HI_W)-1)+((1<<MID_W)-1)+(DATA_W-HI_W-MID_W)-1:0]  sw_ctrl_n
);
    localparam int LO_W   = DATA_W - HI_W - MID_W;
    localparam int HI_N   = (1 << HI_W) - 1;
    localparam int MID_N  = (1 << MID_W) - 1;
    localparam int CTRL_W = HI_N + MID_N + LO_W;

    logic [HI_N-1:0]  hi_seg;
    logic [MID_N-1:0] mid_seg;
    logic [LO_W-1:0]  lo_seg;
    int               wsum;
    logic [1:0]       live_cnt;

    always_comb begin
        hi_seg  = sw_ctrl[CTRL_W-1 -: HI_N];
        mid_seg = sw_ctrl[LO_W +: MID_N];
        lo_seg  = sw_ctrl[LO_W-1:0];
        wsum    = ($countones(hi_seg) << (MID_W + LO_W))
                + ($countones(mid_seg) << LO_W)
                + int'(lo_seg);
    end

    // Count clock edges since reset, saturating at two
    always_ff @(posedge clk) begin
        if (rst) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd2) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    // R2: coarse segment is a bottom-filled run of ones
    p_hi_therm_r2: assert property (@(posedge clk) disable iff (rst)
        (hi_seg & (hi_seg + HI_N'(1))) == '0);

    // R3: fine segment is a bottom-filled run of ones
    p_mid_therm_r3: assert property (@(posedge clk) disable iff (rst)
        (mid_seg & (mid_seg + MID_N'(1))) == '0);

    // R1 / R4: binary bits follow the input two cycles later
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2'd2) |-> (lo_seg == $past(code_in[LO_W-1:0], 2)));

    // R5: weighted sum reproduces the sample from two cycles earlier
    p_wsum_r5: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2'd2) |-> (wsum == int'($past(code_in, 2))));

    // R6: complement bus is the inverse of the true bus
    p_compl_r6: assert property (@(posedge clk)
        (live_cnt != 2'd0) |-> ((sw_ctrl ^ sw_ctrl_n) == {CTRL_W{1'b1}}));

    // R7: reset clears both output registers
    p_reset_r7: assert property (@(posedge clk)
        rst |=> (sw_ctrl == '0) && (sw_ctrl_n == {CTRL_W{1'b1}}));
endmodule

bind segdac_decoder segdac_decoder_chk #(
    .DATA_W (DATA_W),
    .HI_W   (HI_W),
    .MID_W  (MID_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .code_in   (code_in),
    .sw_ctrl   (sw_ctrl),
    .sw_ctrl_n (sw_ctrl_n)
);

// File: tb/segdac_decoder_bench.sv
module segdac_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 14;
    localparam int CTRL_W     = 51;
    localparam int NCODES     = 1 << DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] code_in = '0;
    logic [CTRL_W-1:0] sw_ctrl;
    logic [CTRL_W-1:0] sw_ctrl_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    segdac_decoder u_segdac_decoder (
        .clk       (clk),
        .rst       (rst),
        .code_in   (code_in),
        .sw_ctrl   (sw_ctrl),
        .sw_ctrl_n (sw_ctrl_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check the present output word against an expected input code
    task automatic check_word(input int code, output int wsum);
        logic [30:0] hi;
        logic [14:0] mid;
        logic [4:0]  lo;
        longint      hi_exp, mid_exp;
        hi      = sw_ctrl[50:20];
        mid     = sw_ctrl[19:5];
        lo      = sw_ctrl[4:0];
        hi_exp  = (longint'(1) << (code >> 9)) - 1;
        mid_exp = (longint'(1) << ((code >> 5) & 15)) - 1;
        wsum    = 512 * $countones(hi) + 32 * $countones(mid) + int'(lo);
        chk(longint'(hi) == hi_exp, "R2 coarse thermometer", longint'(hi), hi_exp);
        chk(longint'(mid) == mid_exp, "R3 fine thermometer", longint'(mid), mid_exp);
        chk(int'(lo) == (code & 31), "R4 binary bits", longint'(lo), longint'(code & 31));
        chk(wsum == code, "R5 weighted sum", longint'(wsum), longint'(code));
        chk(sw_ctrl_n == ~sw_ctrl, "R6 complement", longint'(sw_ctrl_n), longint'(~sw_ctrl));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        int ws;
        int prev_sum;
        // Reset with a nonzero input present
        code_in = 14'h2abc;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(sw_ctrl == '0, "R7 reset true bus", longint'(sw_ctrl), 0);
        chk(sw_ctrl_n == {CTRL_W{1'b1}}, "R7 reset complement bus",
            longint'(sw_ctrl_n), longint'({CTRL_W{1'b1}}));

        // Release reset: first output decodes the cleared input register
        rst = 1'b0;
        code_in = 14'h1234;
        @(negedge clk);
        chk(sw_ctrl == '0, "R7 input register cleared", longint'(sw_ctrl), 0);
        @(negedge clk);
        chk(sw_ctrl[4:0] == 5'h14, "R1 two-cycle latency", longint'(sw_ctrl[4:0]), 'h14);
        check_word(14'h1234, ws);

        // Ascending sweep over every code
        prev_sum = 0;
        for (int i = 0; i < NCODES + 1; i++) begin
            if (i < NCODES) code_in = DATA_W'(i);
            @(negedge clk);
            if (i >= 1) begin
                check_word(i - 1, ws);
                if (i >= 2) begin
                    chk(ws == prev_sum + 1, "R8 monotonic step", longint'(ws), longint'(prev_sum + 1));
                end
                prev_sum = ws;
            end
        end

        // Scattered codes with large jumps
        for (int i = 0; i < 257; i++) begin
            if (i < 256) code_in = DATA_W'(i * 4099 + 77);
            @(negedge clk);
            if (i >= 1) begin
                int c;
                c = ((i - 1) * 4099 + 77) & (NCODES - 1);
                chk(int'(sw_ctrl[4:0]) == (c & 31), "R1 latency under jumps",
                    longint'(sw_ctrl[4:0]), longint'(c & 31));
                check_word(c, ws);
            end
        end

        // Reset in the middle of the stream
        code_in = 14'h3fff;
        rst = 1'b1;
        @(negedge clk);
        chk(sw_ctrl == '0, "R7 mid-stream reset", longint'(sw_ctrl), 0);
        chk(sw_ctrl_n == {CTRL_W{1'b1}}, "R7 mid-stream reset complement",
            longint'(sw_ctrl_n), longint'({CTRL_W{1'b1}}));
        rst = 1'b0;
        @(negedge clk);
        chk(sw_ctrl == '0, "R7 input register cleared after reset", longint'(sw_ctrl), 0);
        @(negedge clk);
        check_word(14'h3fff, ws);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end
endmodule